// File: doc/BRIEF.md
# Bidirectional Inter-Processor Mailbox

This block passes short messages between an application processor and an I/O coprocessor. It holds two message queues, and each queue carries traffic in one direction only. The outbound queue runs from the application side to the I/O side. The inbound queue runs from the I/O side back to the application side. A message is a pair of one 64-bit word and one 32-bit word, and it is always queued and removed as a single entry.

Both processors reach the block through their own register port, and both ports decode the same address map. The sender writes the wide word to a staging register. Writing the narrow word then queues the pair. The receiver may peek at the head wide word. Reading the head narrow word removes the entry.

Four separate level-sensitive interrupt lines report the empty and not-empty state of each queue. A parameter selects one of two variants. In one, the lines can be enabled one by one through a register. In the other, they are permanently enabled.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty and their overflow bits are clear. With enable control present, the interrupt enable register reads 0 and all four interrupt lines are low.
- R2: Each status word reads as follows: bit 0 is empty, bit 1 is full, bit 2 is the sticky overflow bit, and bits 15:8 hold the entry count. All other bits read 0. A push becomes visible in the status and interrupt lines in the cycle after the write is accepted.
- R3: Writing address 1 (outbound) or 6 (inbound) stores the 64-bit staging word. Writing address 2 or 7 queues {staging word, wdata[31:0]}. Only the sending side of that queue can do either.
- R4: Reading address 3 (outbound) or 8 (inbound) returns the head wide word without removing it. Reading address 4 or 9 returns the head narrow word in bits 31:0 and removes the entry. Only the receiving side can do either. Entries leave in arrival order. A read response is valid in the cycle after the request.
- R5: Direction is fixed. A push or pop access from the wrong side changes nothing, and a wrong-side read of a data register returns 0. Both status words (address 0 outbound, 5 inbound) are readable from either side.
- R6: A push to a full queue is dropped and sets that queue's overflow bit. This holds even if a pop of the same queue happens in the same cycle. Writing a status word with bit 2 set clears the overflow bit. A drop in the same cycle wins over the clear.
- R7: Popping or peeking an empty queue returns 0 and leaves the queue unchanged.
- R8: A push and a pop of the same non-full, non-empty queue in one cycle both take effect, and the count stays the same.
- R9: The interrupt lines are: outbound-empty = empty & en[0]; outbound-pending = not-empty & en[1]; inbound-empty = empty & en[2]; inbound-pending = not-empty & en[3]. Pending stays high while any entry remains and falls in the cycle after the last pop.
- R10: With enable control present, address 10 bits 3:0 form the enable register, writable and readable from either side. Without it, the register reads 4'hF, writes are ignored, and all lines stay enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ap_req_valid | input | 1 | Application-side request valid |
| ap_req_ready | output | 1 | Application-side request accepted (always high) |
| ap_req_write | input | 1 | Application-side write (1) or read (0) |
| ap_req_addr | input | 4 | Application-side register address |
| ap_req_wdata | input | 64 | Application-side write data |
| ap_rsp_valid | output | 1 | Application-side read data valid |
| ap_rsp_data | output | 64 | Application-side read data |
| io_req_valid | input | 1 | I/O-side request valid |
| io_req_ready | output | 1 | I/O-side request accepted (always high) |
| io_req_write | input | 1 | I/O-side write (1) or read (0) |
| io_req_addr | input | 4 | I/O-side register address |
| io_req_wdata | input | 64 | I/O-side write data |
| io_rsp_valid | output | 1 | I/O-side read data valid |
| io_rsp_data | output | 64 | I/O-side read data |
| irq_out_empty | output | 1 | Outbound queue empty interrupt |
| irq_out_pending | output | 1 | Outbound queue not-empty interrupt |
| irq_in_empty | output | 1 | Inbound queue empty interrupt |
| irq_in_pending | output | 1 | Inbound queue not-empty interrupt |

## Verification
The hardest situation to reach is a queue that is full while the other side pops it in the same cycle. Here the push must still be dropped and the overflow bit set, even though space frees up at that edge. To reach it, the stimulus fills the outbound queue to its depth through the application port. It then drives a push on the application port and a pop on the I/O port in one cycle. The same two-port cycle, on a partly filled queue, covers the push-and-pop case that keeps the count unchanged. A behavioural queue model, updated for both ports each cycle, checks the four interrupt lines on every clock.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam logic [3:0] OFS_STAT   = 4'd0;
  localparam logic [3:0] OFS_TXW    = 4'd1;
  localparam logic [3:0] OFS_TXN    = 4'd2;
  localparam logic [3:0] OFS_RXW    = 4'd3;
  localparam logic [3:0] OFS_RXN    = 4'd4;
  localparam int unsigned REG_STRIDE = 5;
  localparam logic [3:0] ADDR_IRQ_EN = 4'd10;

  typedef struct packed {
    logic [63:0] wide;
    logic [31:0] narrow;
  } msg_t;

  function automatic logic [3:0] reg_addr(int unsigned queue, logic [3:0] ofs);
    return 4'(queue * REG_STRIDE) + ofs;
  endfunction

  function automatic logic [63:0] status_word(logic [7:0] cnt, logic ovf,
                                              logic full, logic empty);
    return {48'b0, cnt, 5'b0, ovf, full, empty};
  endfunction

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_we,
  input  logic [63:0]   stage_d,
  input  logic          push,
  input  logic [31:0]   push_lo,
  input  logic          pop,
  input  logic          ovf_clr,
  output msg_t          head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);

  msg_t          mem [DEPTH];
  logic [63:0]   stage_q;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          ovf_q;

  logic push_ok, pop_ok, push_drop;
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= '{wide: stage_q, narrow: push_lo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (stage_we) stage_q <= stage_d;
      if (push_ok)  wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)   rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
      if (push_drop)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign head  = mem[rd_ptr];
  assign count = count_q;
  assign ovf   = ovf_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_drop_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> ovf_q);
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full && !pop |=> count_q == $past(count_q) + CW'(1));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> $stable(count_q));
  p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty |=> $stable(count_q));

endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned SIDE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [63:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [63:0] rsp_data,
  input  logic [63:0] stat_out,
  input  logic [63:0] stat_in,
  input  msg_t        rx_head,
  input  logic        rx_empty,
  input  logic [3:0]  irq_en,
  output logic        tx_stage_we,
  output logic [63:0] tx_wide,
  output logic        tx_push,
  output logic [31:0] tx_lo,
  output logic        rx_pop,
  output logic [1:0]  ovf_clr,
  output logic        en_we,
  output logic [3:0]  en_d
);

  localparam int unsigned RXQ = 1 - SIDE;
  localparam logic [3:0] A_STAT0 = reg_addr(0, OFS_STAT);
  localparam logic [3:0] A_STAT1 = reg_addr(1, OFS_STAT);
  localparam logic [3:0] A_TXW   = reg_addr(SIDE, OFS_TXW);
  localparam logic [3:0] A_TXN   = reg_addr(SIDE, OFS_TXN);
  localparam logic [3:0] A_RXW   = reg_addr(RXQ, OFS_RXW);
  localparam logic [3:0] A_RXN   = reg_addr(RXQ, OFS_RXN);

  logic wr_acc, rd_acc;
  assign req_ready = 1'b1;
  assign wr_acc    = req_valid && req_write;
  assign rd_acc    = req_valid && !req_write;

  assign tx_stage_we = wr_acc && (req_addr == A_TXW);
  assign tx_wide     = req_wdata;
  assign tx_push     = wr_acc && (req_addr == A_TXN);
  assign tx_lo       = req_wdata[31:0];
  assign rx_pop      = rd_acc && (req_addr == A_RXN);
  assign ovf_clr[0]  = wr_acc && (req_addr == A_STAT0) && req_wdata[2];
  assign ovf_clr[1]  = wr_acc && (req_addr == A_STAT1) && req_wdata[2];
  assign en_we       = wr_acc && (req_addr == ADDR_IRQ_EN);
  assign en_d        = req_wdata[3:0];

  logic [63:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (req_addr == A_STAT0)          rd_mux = stat_out;
    else if (req_addr == A_STAT1)     rd_mux = stat_in;
    else if (req_addr == A_RXW)       rd_mux = rx_empty ? '0 : rx_head.wide;
    else if (req_addr == A_RXN)       rd_mux = rx_empty ? '0 : {32'b0, rx_head.narrow};
    else if (req_addr == ADDR_IRQ_EN) rd_mux = {60'b0, irq_en};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_data  <= rd_acc ? rd_mux : '0;
    end
  end

  p_rsp_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter bit          HAS_IRQ_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ap_req_valid,
  output logic        ap_req_ready,
  input  logic        ap_req_write,
  input  logic [3:0]  ap_req_addr,
  input  logic [63:0] ap_req_wdata,
  output logic        ap_rsp_valid,
  output logic [63:0] ap_rsp_data,
  input  logic        io_req_valid,
  output logic        io_req_ready,
  input  logic        io_req_write,
  input  logic [3:0]  io_req_addr,
  input  logic [63:0] io_req_wdata,
  output logic        io_rsp_valid,
  output logic [63:0] io_rsp_data,
  output logic        irq_out_empty,
  output logic        irq_out_pending,
  output logic        irq_in_empty,
  output logic        irq_in_pending
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [3:0] EN_FIXED = HAS_IRQ_EN ? 4'h0 : 4'hF;
  localparam logic [3:0] EN_WMASK = HAS_IRQ_EN ? 4'hF : 4'h0;

  logic        req_valid_s [2];
  logic        req_write_s [2];
  logic [3:0]  req_addr_s  [2];
  logic [63:0] req_wdata_s [2];
  logic        req_ready_s [2];
  logic        rsp_valid_s [2];
  logic [63:0] rsp_data_s  [2];
  logic        stage_we_s  [2];
  logic [63:0] tx_wide_s   [2];
  logic        push_s      [2];
  logic [31:0] tx_lo_s     [2];
  logic        pop_s       [2];
  logic [1:0]  clr_s       [2];
  logic        en_we_s     [2];
  logic [3:0]  en_d_s      [2];

  msg_t          head_q [2];
  logic [CW-1:0] cnt_q  [2];
  logic          full_q [2];
  logic          empty_q[2];
  logic          ovf_q  [2];
  logic [63:0]   stat_q [2];
  logic [3:0]    en_q;

  assign req_valid_s[0] = ap_req_valid;
  assign req_write_s[0] = ap_req_write;
  assign req_addr_s[0]  = ap_req_addr;
  assign req_wdata_s[0] = ap_req_wdata;
  assign req_valid_s[1] = io_req_valid;
  assign req_write_s[1] = io_req_write;
  assign req_addr_s[1]  = io_req_addr;
  assign req_wdata_s[1] = io_req_wdata;
  assign ap_req_ready   = req_ready_s[0];
  assign ap_rsp_valid   = rsp_valid_s[0];
  assign ap_rsp_data    = rsp_data_s[0];
  assign io_req_ready   = req_ready_s[1];
  assign io_rsp_valid   = rsp_valid_s[1];
  assign io_rsp_data    = rsp_data_s[1];

  for (genvar q = 0; q < 2; q++) begin : g_queue
    ipc_mbox_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .stage_we(stage_we_s[q]),
      .stage_d (tx_wide_s[q]),
      .push    (push_s[q]),
      .push_lo (tx_lo_s[q]),
      .pop     (pop_s[1-q]),
      .ovf_clr (clr_s[0][q] | clr_s[1][q]),
      .head    (head_q[q]),
      .count   (cnt_q[q]),
      .full    (full_q[q]),
      .empty   (empty_q[q]),
      .ovf     (ovf_q[q])
    );
    assign stat_q[q] = status_word(8'(cnt_q[q]), ovf_q[q], full_q[q], empty_q[q]);
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    ipc_mbox_port #(.SIDE(s)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid_s[s]),
      .req_write  (req_write_s[s]),
      .req_addr   (req_addr_s[s]),
      .req_wdata  (req_wdata_s[s]),
      .req_ready  (req_ready_s[s]),
      .rsp_valid  (rsp_valid_s[s]),
      .rsp_data   (rsp_data_s[s]),
      .stat_out   (stat_q[0]),
      .stat_in    (stat_q[1]),
      .rx_head    (head_q[1-s]),
      .rx_empty   (empty_q[1-s]),
      .irq_en     (en_q),
      .tx_stage_we(stage_we_s[s]),
      .tx_wide    (tx_wide_s[s]),
      .tx_push    (push_s[s]),
      .tx_lo      (tx_lo_s[s]),
      .rx_pop     (pop_s[s]),
      .ovf_clr    (clr_s[s]),
      .en_we      (en_we_s[s]),
      .en_d       (en_d_s[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          en_q <= EN_FIXED;
    else if (en_we_s[0]) en_q <= (en_d_s[0] & EN_WMASK) | EN_FIXED;
    else if (en_we_s[1]) en_q <= (en_d_s[1] & EN_WMASK) | EN_FIXED;
  end

  assign irq_out_empty   =  empty_q[0] & en_q[0];
  assign irq_out_pending = !empty_q[0] & en_q[1];
  assign irq_in_empty    =  empty_q[1] & en_q[2];
  assign irq_in_pending  = !empty_q[1] & en_q[3];

  p_pending_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_s[1] && cnt_q[0] > CW'(1) && en_q[1] && !en_we_s[0] && !en_we_s[1]
    |=> irq_out_pending);
  p_pending_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_s[1] && cnt_q[0] == CW'(1) && !push_s[0] |=> !irq_out_pending);

endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ap_v = 0, ap_w = 0, io_v = 0, io_w = 0;
  logic [3:0] ap_a = 0, io_a = 0;
  logic [63:0] ap_d = 0, io_d = 0;
  logic ap_rdy, ap_rv, io_rdy, io_rv;
  logic [63:0] ap_rd, io_rd;
  logic irq_oe, irq_op, irq_ie, irq_ip;

  ipc_mailbox #(.DEPTH(D), .HAS_IRQ_EN(1'b1)) i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n),
    .ap_req_valid(ap_v), .ap_req_ready(ap_rdy), .ap_req_write(ap_w),
    .ap_req_addr(ap_a), .ap_req_wdata(ap_d), .ap_rsp_valid(ap_rv), .ap_rsp_data(ap_rd),
    .io_req_valid(io_v), .io_req_ready(io_rdy), .io_req_write(io_w),
    .io_req_addr(io_a), .io_req_wdata(io_d), .io_rsp_valid(io_rv), .io_rsp_data(io_rd),
    .irq_out_empty(irq_oe), .irq_out_pending(irq_op),
    .irq_in_empty(irq_ie), .irq_in_pending(irq_ip));

  logic n_v = 0, n_w = 0;
  logic [3:0] n_a = 0;
  logic [63:0] n_d = 0;
  logic n_rdy, n_rv, n_io_rdy, n_io_rv;
  logic [63:0] n_rd, n_io_rd;
  logic n_oe, n_op, n_ie, n_ip;

  ipc_mailbox #(.DEPTH(D), .HAS_IRQ_EN(1'b0)) i_ipc_mailbox_fixed (
    .clk(clk), .rst_n(rst_n),
    .ap_req_valid(n_v), .ap_req_ready(n_rdy), .ap_req_write(n_w),
    .ap_req_addr(n_a), .ap_req_wdata(n_d), .ap_rsp_valid(n_rv), .ap_rsp_data(n_rd),
    .io_req_valid(1'b0), .io_req_ready(n_io_rdy), .io_req_write(1'b0),
    .io_req_addr(4'd0), .io_req_wdata(64'd0), .io_rsp_valid(n_io_rv), .io_rsp_data(n_io_rd),
    .irq_out_empty(n_oe), .irq_out_pending(n_op),
    .irq_in_empty(n_ie), .irq_in_pending(n_ip));

  int nchk = 0, nfail = 0;
  bit run_cmp = 0, done = 0;

  // behavioural reference model
  logic [95:0] mq0[$];
  logic [95:0] mq1[$];
  logic [63:0] mst0 = 0, mst1 = 0;
  bit movf0 = 0, movf1 = 0;
  logic [3:0] men = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    mq0.delete(); mq1.delete();
    mst0 = 0; mst1 = 0; movf0 = 0; movf1 = 0; men = 0;
  endtask

  function automatic logic [63:0] model_read(input bit s, input logic [3:0] a);
    if (a == 4'd0) return {48'b0, 8'(mq0.size()), 5'b0, movf0, mq0.size() == D, mq0.size() == 0};
    if (a == 4'd5) return {48'b0, 8'(mq1.size()), 5'b0, movf1, mq1.size() == D, mq1.size() == 0};
    if (a == 4'd10) return {60'b0, men};
    if (s && a == 4'd3 && mq0.size() > 0) return mq0[0][95:32];
    if (s && a == 4'd4 && mq0.size() > 0) return {32'b0, mq0[0][31:0]};
    if (!s && a == 4'd8 && mq1.size() > 0) return mq1[0][95:32];
    if (!s && a == 4'd9 && mq1.size() > 0) return {32'b0, mq1[0][31:0]};
    return 64'd0;
  endfunction

  task automatic model_cycle(input bit av, input bit aw, input logic [3:0] aa, input logic [63:0] ad,
                             input bit iv, input bit iw, input logic [3:0] ia, input logic [63:0] id);
    int c0 = mq0.size();
    int c1 = mq1.size();
    bit clr0 = 0, clr1 = 0, push0 = 0, push1 = 0, pop0 = 0, pop1 = 0;
    logic [31:0] lo0 = 0, lo1 = 0;
    logic [63:0] nst0 = mst0, nst1 = mst1;
    for (int s = 1; s >= 0; s--) begin
      bit v = s ? iv : av;
      bit w = s ? iw : aw;
      logic [3:0] a = s ? ia : aa;
      logic [63:0] d = s ? id : ad;
      if (v && w) begin
        if (a == 4'd0 && d[2]) clr0 = 1;
        if (a == 4'd5 && d[2]) clr1 = 1;
        if (s == 0 && a == 4'd1) nst0 = d;
        if (s == 0 && a == 4'd2) begin push0 = 1; lo0 = d[31:0]; end
        if (s == 1 && a == 4'd6) nst1 = d;
        if (s == 1 && a == 4'd7) begin push1 = 1; lo1 = d[31:0]; end
        if (a == 4'd10) men = d[3:0];
      end else if (v) begin
        if (s == 1 && a == 4'd4) pop0 = 1;
        if (s == 0 && a == 4'd9) pop1 = 1;
      end
    end
    if (push0 && c0 >= D) movf0 = 1; else if (clr0) movf0 = 0;
    if (push1 && c1 >= D) movf1 = 1; else if (clr1) movf1 = 0;
    if (pop0 && c0 > 0) void'(mq0.pop_front());
    if (pop1 && c1 > 0) void'(mq1.pop_front());
    if (push0 && c0 < D) mq0.push_back({mst0, lo0});
    if (push1 && c1 < D) mq1.push_back({mst1, lo1});
    mst0 = nst0; mst1 = nst1;
  endtask

  task automatic step(input bit av, input bit aw, input logic [3:0] aa, input logic [63:0] ad,
                      input bit iv, input bit iw, input logic [3:0] ia, input logic [63:0] id,
                      input string tag);
    logic [63:0] ea = model_read(0, aa);
    logic [63:0] ei = model_read(1, ia);
    ap_v = av; ap_w = aw; ap_a = aa; ap_d = ad;
    io_v = iv; io_w = iw; io_a = ia; io_d = id;
    @(posedge clk);
    model_cycle(av, aw, aa, ad, iv, iw, ia, id);
    @(negedge clk);
    ap_v = 0; io_v = 0;
    if (av && !aw) begin chk({tag, " ap rsp_valid"}, 64'(ap_rv), 64'd1); chk({tag, " ap data"}, ap_rd, ea); end
    if (iv && !iw) begin chk({tag, " io rsp_valid"}, 64'(io_rv), 64'd1); chk({tag, " io data"}, io_rd, ei); end
  endtask

  task automatic ap(input bit w, input logic [3:0] a, input logic [63:0] d, input string tag);
    step(1, w, a, d, 0, 0, 4'd0, 64'd0, tag);
  endtask
  task automatic io(input bit w, input logic [3:0] a, input logic [63:0] d, input string tag);
    step(0, 0, 4'd0, 64'd0, 1, w, a, d, tag);
  endtask

  task automatic n_step(input bit w, input logic [3:0] a, input logic [63:0] d, output logic [63:0] r);
    n_v = 1; n_w = w; n_a = a; n_d = d;
    @(posedge clk);
    @(negedge clk);
    n_v = 0;
    r = n_rd;
  endtask

  // every-clock comparison of the interrupt lines (R9)
  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R9 irq_out_empty", 64'(irq_oe), 64'(mq0.size() == 0 && men[0]));
      chk("R9 irq_out_pending", 64'(irq_op), 64'(mq0.size() != 0 && men[1]));
      chk("R9 irq_in_empty", 64'(irq_ie), 64'(mq1.size() == 0 && men[2]));
      chk("R9 irq_in_pending", 64'(irq_ip), 64'(mq1.size() != 0 && men[3]));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;

    // R1 reset state
    ap(0, 4'd0, 0, "R1"); io(0, 4'd5, 0, "R1"); ap(0, 4'd10, 0, "R1");
    chk("R1 irq lines", {60'b0, irq_oe, irq_op, irq_ie, irq_ip}, 64'd0);
    // R10 fixed-enable variant
    chk("R10 fixed irqs at reset", {60'b0, n_oe, n_op, n_ie, n_ip}, 64'b1010);
    n_step(1, 4'd10, 64'd0, r);
    n_step(0, 4'd10, 64'd0, r);
    chk("R10 fixed enable reads F after write", r, 64'hF);
    n_step(1, 4'd1, 64'h1234, r);
    n_step(1, 4'd2, 64'h55, r);
    chk("R10 fixed pending rises", {60'b0, n_oe, n_op, n_ie, n_ip}, 64'b0110);

    // R10 enable register, written by one side, read by the other
    ap(1, 4'd10, 64'hF, "R10"); io(0, 4'd10, 0, "R10");

    // R3 / R2 pushes outbound
    ap(1, 4'd1, 64'hA5A5_0000_1111_2222, "R3"); ap(1, 4'd2, 64'hC0DE_0001, "R3");
    chk("R2 pending visible after push", 64'(irq_op), 64'd1);
    ap(1, 4'd1, 64'h0123_4567_89AB_CDEF, "R3"); ap(1, 4'd2, 64'hC0DE_0002, "R3");
    ap(1, 4'd1, 64'hFFFF_0000_FFFF_0000, "R3"); ap(1, 4'd2, 64'hC0DE_0003, "R3");
    io(0, 4'd0, 0, "R2"); ap(0, 4'd0, 0, "R5");
    // R4 peek then pop in order
    io(0, 4'd3, 0, "R4"); chk("R4 peek literal", io_rd, 64'hA5A5_0000_1111_2222);
    io(0, 4'd3, 0, "R4");
    io(0, 4'd4, 0, "R4"); chk("R4 pop literal", io_rd, 64'hC0DE_0001);
    // R5 wrong-side accesses
    io(1, 4'd1, 64'hDEAD, "R5"); io(1, 4'd2, 64'hBEEF, "R5");
    ap(0, 4'd4, 0, "R5"); ap(0, 4'd3, 0, "R5");
    chk("R5 wrong side pop reads zero", ap_rd, 64'd0);
    ap(1, 4'd6, 64'h77, "R5"); ap(1, 4'd7, 64'h78, "R5");
    io(0, 4'd5, 0, "R5"); io(0, 4'd0, 0, "R5");
    // R8 simultaneous push and pop
    step(1, 1, 4'd2, 64'hC0DE_0004, 1, 0, 4'd4, 0, "R8");
    io(0, 4'd0, 0, "R8");
    // R6 fill and overflow
    for (int i = 0; mq0.size() < D; i++) begin
      ap(1, 4'd1, 64'h1000 + 64'(i), "R6"); ap(1, 4'd2, 64'h2000 + 64'(i), "R6");
    end
    ap(1, 4'd2, 64'h9999, "R6");
    io(0, 4'd0, 0, "R6"); chk("R6 full with overflow", io_rd, 64'h806);
    io(1, 4'd0, 64'h4, "R6");
    ap(0, 4'd0, 0, "R6"); chk("R6 overflow cleared", ap_rd, 64'h802);
    step(1, 1, 4'd2, 64'hAAAA, 1, 0, 4'd4, 0, "R6");
    io(0, 4'd0, 0, "R6"); chk("R6 drop wins over same-cycle pop", io_rd, 64'h704);
    // R6 drop and clear in one cycle: drop wins
    ap(1, 4'd2, 64'hBBBB, "R6");
    step(1, 1, 4'd2, 64'hCCCC, 1, 1, 4'd0, 64'h4, "R6");
    io(0, 4'd0, 0, "R6");
    io(1, 4'd0, 64'h4, "R6");
    // drain and R7 empty reads
    for (int i = 0; mq0.size() > 0 && i < 20; i++) begin
      io(0, 4'd3, 0, "R4"); io(0, 4'd4, 0, "R4");
    end
    io(0, 4'd4, 0, "R7"); chk("R7 empty pop reads zero", io_rd, 64'd0);
    io(0, 4'd3, 0, "R7"); io(0, 4'd0, 0, "R7");
    // inbound direction and R9 level behaviour
    io(1, 4'd6, 64'h6666_0000_0000_0001, "R3"); io(1, 4'd7, 64'h51, "R3");
    io(1, 4'd6, 64'h6666_0000_0000_0002, "R3"); io(1, 4'd7, 64'h52, "R3");
    ap(0, 4'd8, 0, "R4"); ap(0, 4'd9, 0, "R4"); chk("R4 inbound pop literal", ap_rd, 64'h51);
    chk("R9 pending held with entry left", 64'(irq_ip), 64'd1);
    ap(0, 4'd9, 0, "R4");
    chk("R9 pending falls after last pop", {62'b0, irq_ie, irq_ip}, 64'b10);
    ap(0, 4'd9, 0, "R7");
    // R10 masking
    io(1, 4'd10, 64'h5, "R10");
    ap(1, 4'd1, 64'h1, "R10"); ap(1, 4'd2, 64'h2, "R10");
    chk("R10 masked pending stays low", 64'(irq_op), 64'd0);
    ap(0, 4'd10, 0, "R10");
    // R1 reset again clears queues and masks
    run_cmp = 0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    model_clear();
    rst_n = 1;
    run_cmp = 1;
    ap(0, 4'd10, 0, "R1"); io(0, 4'd0, 0, "R1");
    chk("R1 status after reset", io_rd, 64'h1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule